// File: doc/BRIEF.md
# Synchronous Bus Read/Write Master with Wait States

This block turns single word requests from a user-side port into read and write cycles on a clocked, non-multiplexed memory bus. The bus has separate address and data lines and three active-low controls: a memory-request strobe, a read strobe and a wait line driven by the slave. Every bus event is timed to one clock edge. At the nominal 40 MHz bus clock each clock lasts 25 ns.

The user raises `req_start` for one clock while `req_ready` is high. The request carries an address, a direction and the write data. The master then places the address on the bus for one full clock before it lowers any strobe, so that the slave's address decode can settle. It then lowers the strobes and keeps them low for as long as the slave holds the wait line low. In one final clock it samples read data and releases the strobes. One clock later it reports `rsp_done`, and for a read it presents the sampled word on `rsp_rdata`.

The controller is a single state machine with six named states:
- IDLE: waiting for a request.
- ADDR (T1): address driven, strobes high.
- STRB (T2): strobes asserted.
- WAIT: a slave-inserted wait state.
- SAMP (T3): the final strobe clock, in which data is sampled.
- DONE: the completion pulse.

The transitions are:
- IDLE→ADDR when a request is accepted.
- ADDR→STRB always.
- STRB→WAIT, or WAIT→WAIT, when the wait line is seen low.
- STRB→SAMP, or WAIT→SAMP, when the wait line is seen high.
- SAMP→DONE always.
- DONE→IDLE always.

Top module: `sync_bus_master`

## Requirements
- R1: After reset `bus_mreq_n` and `bus_rd_n` are high (1), `bus_wdata_oe` and `rsp_done` are low, and `req_ready` is high.
- R2: A request is taken only when `req_start` is 1 in a clock where `req_ready` is 1. `req_start` raised while the master is busy has no effect: it causes no further bus cycle and does not alter the current one.
- R3: The request address appears on `bus_addr` one full clock before `bus_mreq_n` falls, and stays unchanged for as long as `bus_mreq_n` is low.
- R4: In a read (`req_write`=0), `bus_mreq_n` and `bus_rd_n` fall in the same clock and rise together. `bus_rd_n` is never low while `bus_mreq_n` is high.
- R5: In a write (`req_write`=1), `bus_rd_n` stays high throughout. `bus_wdata_oe` is 1 exactly in the clocks where `bus_mreq_n` is low, and `bus_wdata` then carries the request's write data.
- R6: While `bus_mreq_n` is low, a clock edge at which `bus_wait_n` is 0 is followed by a clock in which the strobes are still low.
- R7: Read data is sampled from `bus_rdata` at the end of the last strobe clock, after `bus_wait_n` has been seen high. It is shown on `rsp_rdata` while `rsp_done` is 1.
- R8: `rsp_done` is a single-clock pulse in the clock right after the strobes rise.
- R9: With N wait states (N clock edges with `bus_wait_n` seen low during the strobes), the strobes stay low for 2+N clocks. `rsp_done` appears 4+N clocks after the clock in which the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when `req_ready` is high |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Master idle and able to take a request |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Last word read from the bus |
| bus_addr | output | ADDR_W | Bus address lines |
| bus_mreq_n | output | 1 | Active-low memory request strobe |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wait_n | input | 1 | Active-low wait from the slave |
| bus_wdata | output | DATA_W | Write data toward the bus |
| bus_wdata_oe | output | 1 | Drive enable for the write data lines |
| bus_rdata | input | DATA_W | Read data from the bus |

## Verification
The bench runs reads and writes against a slave model whose wait count is set from 0 to 3. It measures the strobe width and the request-to-done latency.
- A master that ignores the wait line, or counts it one clock late, gives the wrong strobe width.
- A master that samples data before the wait is released returns the wrong word.
- A master that lowers the strobes together with the address shows a different address in the clock before the strobes fall.
- A write that pulses the read strobe is caught as a change of `bus_rd_n` during the strobes.

A start pulse is also raised in the middle of a busy cycle. A master that accepts it shows a second strobe fall or a changed address.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ADDR = 3'd1,
        S_STRB = 3'd2,
        S_WAIT = 3'd3,
        S_SAMP = 3'd4,
        S_DONE = 3'd5
    } sbm_state_e;
endpackage

// File: rtl/sbm_seq.sv
module sbm_seq
    import sbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept,
    input  logic       wait_n,
    output sbm_state_e state
);
    sbm_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept) state_nx = S_ADDR;
            S_ADDR:  state_nx = S_STRB;
            S_STRB:  state_nx = wait_n ? S_SAMP : S_WAIT;
            S_WAIT:  state_nx = wait_n ? S_SAMP : S_WAIT;
            S_SAMP:  state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_STRB || state == S_WAIT) && !wait_n) |=> (state == S_WAIT));

    // R9
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR) |=> (state == S_STRB));
endmodule

// File: rtl/sbm_req_hold.sv
module sbm_req_hold #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    output logic              hold_write,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_wdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_write <= 1'b0;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if (load) begin
            hold_write <= in_write;
            hold_addr  <= in_addr;
            hold_wdata <= in_wdata;
        end
    end
endmodule

// File: rtl/sbm_rd_capture.sv
module sbm_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_word,
    output logic [DATA_W-1:0] held_word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       held_word <= '0;
        else if (capture) held_word <= bus_word;
    end
endmodule

// File: rtl/sync_bus_master.sv
module sync_bus_master
    import sbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mreq_n,
    output logic              bus_rd_n,
    input  logic              bus_wait_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata
);
    sbm_state_e        state;
    logic              accept;
    logic              strobing;
    logic              hold_write;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;

    assign accept = req_start && (state == S_IDLE);

    sbm_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .wait_n (bus_wait_n),
        .state  (state)
    );

    sbm_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .in_write   (req_write),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .hold_write (hold_write),
        .hold_addr  (hold_addr),
        .hold_wdata (hold_wdata)
    );

    sbm_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   ((state == S_SAMP) && !hold_write),
        .bus_word  (bus_rdata),
        .held_word (rsp_rdata)
    );

    always_comb begin
        strobing = 1'b0;
        unique case (state)
            S_STRB, S_WAIT, S_SAMP: strobing = 1'b1;
            default:                strobing = 1'b0;
        endcase
        req_ready    = (state == S_IDLE);
        rsp_done     = (state == S_DONE);
        bus_addr     = hold_addr;
        bus_wdata    = hold_wdata;
        bus_mreq_n   = !strobing;
        bus_rd_n     = !(strobing && !hold_write);
        bus_wdata_oe = strobing && hold_write;
    end

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && req_ready) |=> !req_ready);

    // R3
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_mreq_n) |-> $stable(bus_addr));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && $past(!bus_mreq_n)) |-> $stable(bus_addr));

    // R4
    rd_inside_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mreq_n |-> bus_rd_n);

    // R4
    rd_fall_with_mreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n) |-> $fell(bus_mreq_n));

    // R5
    wdata_oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wdata_oe |-> (!bus_mreq_n && bus_rd_n));

    // R6
    strobe_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && !bus_wait_n) |=> !bus_mreq_n);

    // R8
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mreq_n) |-> rsp_done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/sync_bus_master_tb.sv
module sync_bus_master_tb;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_mreq_n, bus_rd_n, bus_wait_n, bus_wdata_oe;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sync_bus_master #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_mreq_n(bus_mreq_n), .bus_rd_n(bus_rd_n), .bus_wait_n(bus_wait_n),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata)
    );

    // ---------------- slave model ----------------
    logic [3:0]    wait_cfg = 4'd0;
    logic [3:0]    wcnt;
    logic [AW-1:0] wr_addr_seen;
    logic [DW-1:0] wr_data_seen;

    function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
        return {a[7:0], ~a[15:8]} ^ 16'h3C5A;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wcnt <= '0;
        else if (bus_mreq_n) wcnt <= '0;
        else                 wcnt <= wcnt + 4'd1;
    end

    assign bus_wait_n = !(!bus_mreq_n && (wcnt < wait_cfg));
    assign bus_rdata  = (!bus_mreq_n && !bus_rd_n) ? slave_word(bus_addr) : 16'hDEAD;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_seen <= '0;
            wr_data_seen <= '0;
        end else if (!bus_mreq_n && bus_rd_n && bus_wait_n && bus_wdata_oe) begin
            wr_addr_seen <= bus_addr;
            wr_data_seen <= bus_wdata;
        end
    end

    // ---------------- bus monitor ----------------
    logic          prev_mreq_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    int            strobe_len = 0;
    int            n_falls = 0;
    logic [AW-1:0] t1_addr = '0;
    logic          rd_fell_with = 1'b0;
    logic          rd_moved = 1'b0;
    logic          addr_moved = 1'b0;
    logic          oe_bad = 1'b0;
    logic          rd_at_fall = 1'b1;
    logic [AW-1:0] t2_addr = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (!bus_mreq_n && prev_mreq_n) begin
                strobe_len   <= 1;
                n_falls      <= n_falls + 1;
                t1_addr      <= prev_addr;
                t2_addr      <= bus_addr;
                rd_at_fall   <= bus_rd_n;
                rd_fell_with <= !bus_rd_n;
                rd_moved     <= 1'b0;
                addr_moved   <= 1'b0;
                oe_bad       <= 1'b0;
            end else if (!bus_mreq_n) begin
                strobe_len <= strobe_len + 1;
                if (bus_rd_n != rd_at_fall) rd_moved <= 1'b1;
                if (bus_addr != t2_addr)    addr_moved <= 1'b1;
            end
            if (bus_wdata_oe == bus_mreq_n && !bus_rd_n == 1'b0 && !bus_mreq_n && !bus_wdata_oe && rd_at_fall)
                oe_bad <= 1'b1;
        end
        prev_mreq_n <= bus_mreq_n;
        prev_addr   <= bus_addr;
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog R9: actual cycles %0d expected below %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Runs one transfer and checks it; optional busy start pulse mid-cycle.
    task automatic run_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int waits, input bit poke_busy);
        int lat;
        int falls0;
        lat = 0;
        falls0 = n_falls;
        wait_cfg = 4'(waits);
        @(negedge clk);
        check(req_ready == 1'b1, "R2", "ready before start", int'(req_ready), 1);
        req_start = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_start = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 40) begin
            if (poke_busy && lat == 2) begin
                req_start = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~d;
            end else begin
                req_start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        req_start = 1'b0;
        check(rsp_done == 1'b1, "R8", "done seen", int'(rsp_done), 1);
        check(lat == 4 + waits, "R9", "request to done latency", lat, 4 + waits);
        check(strobe_len == 2 + waits, "R6", "strobe width in clocks", strobe_len, 2 + waits);
        check(n_falls == falls0 + 1, "R2", "one strobe fall per request", n_falls - falls0, 1);
        check(t1_addr == a, "R3", "address in clock before strobes", int'(t1_addr), int'(a));
        check(!addr_moved && t2_addr == a, "R3", "address held in strobes", int'(t2_addr), int'(a));
        check(bus_mreq_n == 1'b1, "R8", "strobes released at done", int'(bus_mreq_n), 1);
        if (wr) begin
            check(rd_at_fall == 1'b1 && !rd_moved, "R5", "read strobe high in write",
                  int'(rd_at_fall), 1);
            check(wr_data_seen == d && wr_addr_seen == a, "R5", "slave write data",
                  int'(wr_data_seen), int'(d));
        end else begin
            check(rd_fell_with && !rd_moved, "R4", "read strobe with request strobe",
                  int'(rd_fell_with), 1);
            check(rsp_rdata == slave_word(a), "R7", "read data with done",
                  int'(rsp_rdata), int'(slave_word(a)));
        end
        @(negedge clk);
        check(rsp_done == 1'b0, "R8", "done is one clock", int'(rsp_done), 0);
        check(req_ready == 1'b1, "R2", "idle after done", int'(req_ready), 1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(bus_mreq_n && bus_rd_n, "R1", "strobes high in reset", int'({bus_mreq_n, bus_rd_n}), 3);
        check(!rsp_done && !bus_wdata_oe, "R1", "done and oe low in reset",
              int'({rsp_done, bus_wdata_oe}), 0);
        check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_mreq_n && bus_rd_n && req_ready, "R1", "idle after reset",
              int'({bus_mreq_n, bus_rd_n, req_ready}), 7);
    endtask

    task automatic test_reads();
        for (int w = 0; w < 4; w++)
            run_txn(1'b0, 16'h1200 + 16'(w * 33), '0, w, 1'b0);
    endtask

    task automatic test_writes();
        for (int w = 0; w < 4; w++)
            run_txn(1'b1, 16'h8001 + 16'(w * 7), 16'hA500 + 16'(w), w, 1'b0);
    endtask

    task automatic test_busy_start();
        logic [DW-1:0] keep;
        int falls0;
        run_txn(1'b0, 16'h0F0F, '0, 2, 1'b1);
        keep = rsp_rdata;
        falls0 = n_falls;
        repeat (6) @(negedge clk);
        check(n_falls == falls0, "R2", "no extra cycle after busy start", n_falls - falls0, 0);
        check(keep == slave_word(16'h0F0F), "R2", "busy start left read intact",
              int'(keep), int'(slave_word(16'h0F0F)));
        run_txn(1'b1, 16'h4444, 16'h7E7E, 3, 1'b1);
    endtask

    initial begin
        test_reset();
        test_reads();
        test_writes();
        test_busy_start();
        run_txn(1'b0, 16'hFFFF, '0, 0, 1'b0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule